// File: doc/BRIEF.md
# SPI Master with Chip-Select Hold

This block is an SPI master that shifts 8-bit words out on MOSI and in from MISO. It drives four active-low chip-select lines, one per attached peripheral. Software hands it one word at a time, each tagged with a 2-bit select code and a keep-selected flag. A one-deep holding stage accepts the word. A transmit-empty flag tells software when the next word may be queued. SCK idles low. Data changes on the falling edge of SCK and is sampled on the rising edge, most significant bit first. The half period of SCK is a programmable number of system clocks.

Between words the block inserts a programmable turnaround delay. It inserts a second programmable delay whenever a chip select goes high before another one, or the same one, goes low again. If the keep-selected flag of a word is set, its chip select stays low after the word ends. It goes high only when a later word names a different peripheral. Otherwise every word ends with its select released.

The shared slave-select input is passed through a synchronizer. If it is seen low while the block is enabled and detection is not masked, the block reports a multi-master conflict. It then turns itself off, and a sticky fault flag stays set until software acknowledges it. While the block is off, all selects stay high, SCK stays low and writes are refused. Software must pulse the enable input to resume.

Top module: `spi_cs_master`

## Requirements
- R1: After reset, cs_n_o is 4'b1111, sck_o is 0, tx_empty_o is 1, modf_o is 0 and enabled_o is 0. A pulse on en_set_i sets enabled_o on the next cycle.
- R2: A tx_wr_i pulse is accepted only while tx_empty_o is 1 and enabled_o is 1. Accepting it drops tx_empty_o on the next cycle. Any other write has no effect: it changes no transmitted byte and adds no transfer. tx_empty_o rises again once the word has been taken for transmission.
- R3: Each transfer sends tx_data_i on mosi_o MSB first. mosi_o changes only while sck_o is low, and miso_i is sampled when sck_o rises. SCK stays high for max(1, clk_div_i) clock cycles. At the end of the transfer, rx_valid_o pulses for one cycle with the 8 received bits (first bit received in bit 7).
- R4: Select code s (0 to 3) drives cs_n_o[s] low for the transfer, and never more than one cs_n_o bit is low.
- R5: With keep-selected 0, the select goes high after the transfer. When the next word is already queued, cs_n_o stays all-high for max(1,dly_xfer_i) + 1 + max(1,dly_cs_i) cycles.
- R6: With keep-selected 1, and a next word that uses the same select code, cs_n_o stays low without a break through the next transfer.
- R7: With keep-selected 1, and a next word that uses a different code, the old select goes high when that word is taken. cs_n_o stays all-high for max(1,dly_cs_i) cycles before the new select goes low.
- R8: If the block is enabled, modf_off_i is 0 and nss_i is low, then within five cycles: enabled_o is 0, modf_o is 1, cs_n_o is 4'b1111, sck_o is 0, any queued word is dropped (tx_empty_o is 1) and the transfer in progress is abandoned.
- R9: modf_o stays 1 until a stat_rd_i pulse. enabled_o stays 0 until an en_set_i pulse, whatever happens on nss_i or tx_wr_i in the meantime.
- R10: With modf_off_i at 1, a low nss_i has no effect: modf_o stays 0 and transfers complete normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_set_i | input | 1 | Pulse: enable the block |
| stat_rd_i | input | 1 | Pulse: status read, clears the fault flag |
| modf_off_i | input | 1 | 1 masks multi-master fault detection |
| clk_div_i | input | 8 | SCK half period in clocks (0 acts as 1) |
| dly_xfer_i | input | 8 | Delay after each transfer in clocks (0 acts as 1) |
| dly_cs_i | input | 8 | Delay before a select goes low again in clocks (0 acts as 1) |
| tx_wr_i | input | 1 | Pulse: write a transmit word |
| tx_data_i | input | 8 | Transmit byte |
| tx_sel_i | input | 2 | Peripheral select code for the word |
| tx_hold_i | input | 1 | Keep the select low after this word |
| tx_empty_o | output | 1 | Holding stage free |
| enabled_o | output | 1 | Block enabled |
| modf_o | output | 1 | Sticky multi-master fault flag |
| rx_valid_o | output | 1 | One-cycle pulse: received byte valid |
| rx_data_o | output | 8 | Received byte |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| nss_i | input | 1 | Shared slave-select input watched for faults |
| cs_n_o | output | 4 | Active-low peripheral selects |

## Verification
The bench uses the default parameters: 8-bit words, four selects, an 8-bit divisor and 8-bit delay fields, and a two-stage synchronizer. It only drives divisors from 0 to 3 and delays from 0 to 6, so each word takes a few dozen cycles. That keeps dozens of random words, and the exact gap counts for released, held and switched selects, inside a short run. A 0 in each field checks that zero behaves like one. A divisor of 8 during the fault test leaves a transfer long enough to be cut off part way through.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // Sequencer phases of the transfer engine
    typedef enum logic [1:0] {
        SQ_IDLE     = 2'd0,
        SQ_CS_GAP   = 2'd1,
        SQ_SHIFT    = 2'd2,
        SQ_XFER_GAP = 2'd3
    } seq_state_e;

endpackage

// File: rtl/spim_modf_guard.sv
// Synchronizes the shared slave-select input and owns the enable and
// multi-master fault flags.
module spim_modf_guard #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nss_i,
    input  logic detect_off_i,
    input  logic en_set_i,
    input  logic stat_rd_i,
    output logic en_o,
    output logic modf_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   en;
        logic                   modf;
    } guard_t;

    guard_t q, d;
    logic   nss_s;
    logic   fault;

    assign nss_s = q.sync[SYNC_STAGES-1];

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], nss_i};
        fault  = q.en && !detect_off_i && !nss_s;
        if (stat_rd_i) d.modf = 1'b0;
        if (en_set_i)  d.en   = 1'b1;
        if (fault) begin
            d.en   = 1'b0;
            d.modf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= '1;
            q.en   <= 1'b0;
            q.modf <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign en_o   = q.en;
    assign modf_o = q.modf;

    // R8
    modf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && !detect_off_i && !nss_s) |=> (!en_o && modf_o));

    // R9
    modf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (modf_o && !stat_rd_i) |=> modf_o);

    // R9
    en_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !en_set_i) |=> !en_o);

    // R10
    modf_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (detect_off_i && !modf_o) |=> !modf_o);

endmodule

// File: rtl/spim_shift.sv
// Mode 0 shift engine: SCK idles low, MOSI moves on falling edges,
// MISO captured on rising edges, MSB first.
module spim_shift #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              miso_i,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_o
);

    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        logic              busy;
        logic              sck;
        logic [DIV_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W-1:0] sr;
        logic [DATA_W-1:0] rx;
        logic              done;
    } shift_t;

    shift_t           q, d;
    logic [DIV_W-1:0] half_last;

    assign half_last = (div_i == '0) ? '0 : div_i - DIV_W'(1);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (abort_i) begin
            d.busy = 1'b0;
            d.sck  = 1'b0;
            d.cnt  = '0;
        end else if (start_i) begin
            d.busy = 1'b1;
            d.sck  = 1'b0;
            d.cnt  = '0;
            d.bitn = '0;
            d.sr   = data_i;
        end else if (q.busy) begin
            if (q.cnt == half_last) begin
                d.cnt = '0;
                if (!q.sck) begin
                    d.sck = 1'b1;
                    d.rx  = {q.rx[DATA_W-2:0], miso_i};
                end else begin
                    d.sck = 1'b0;
                    if (q.bitn == BIT_W'(DATA_W - 1)) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.bitn = q.bitn + BIT_W'(1);
                        d.sr   = {q.sr[DATA_W-2:0], 1'b0};
                    end
                end
            end else begin
                d.cnt = q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sck_o  = q.sck;
    assign mosi_o = q.sr[DATA_W-1];
    assign done_o = q.done;
    assign rx_o   = q.rx;

    // R3
    mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> $stable(mosi_o));

endmodule

// File: rtl/spim_seq.sv
// Holding stage, chip-select control and inter-transfer delays.
module spim_seq
    import spim_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NUM_CS = 4,
    parameter int DLY_W  = 8,
    localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic              wr_hold_i,
    input  logic [DLY_W-1:0]  dly_xfer_i,
    input  logic [DLY_W-1:0]  dly_cs_i,
    input  logic              shift_done_i,
    output logic              tx_empty_o,
    output logic              start_o,
    output logic              abort_o,
    output logic [DATA_W-1:0] data_o,
    output logic [NUM_CS-1:0] cs_n_o
);

    typedef struct packed {
        seq_state_e        st;
        logic              pend;
        logic [DATA_W-1:0] pend_data;
        logic [SEL_W-1:0]  pend_sel;
        logic              pend_hold;
        logic [DATA_W-1:0] cur_data;
        logic [SEL_W-1:0]  cur_sel;
        logic              cur_hold;
        logic              cs_act;
        logic [DLY_W-1:0]  cnt;
        logic              start;
    } seq_t;

    seq_t             q, d;
    logic [DLY_W-1:0] xfer_last;
    logic [DLY_W-1:0] cs_last;

    assign xfer_last = (dly_xfer_i == '0) ? '0 : dly_xfer_i - DLY_W'(1);
    assign cs_last   = (dly_cs_i   == '0) ? '0 : dly_cs_i   - DLY_W'(1);

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (!en_i) begin
            d.st     = SQ_IDLE;
            d.pend   = 1'b0;
            d.cs_act = 1'b0;
            d.cnt    = '0;
        end else begin
            if (wr_i && !q.pend) begin
                d.pend      = 1'b1;
                d.pend_data = wr_data_i;
                d.pend_sel  = wr_sel_i;
                d.pend_hold = wr_hold_i;
            end
            unique case (q.st)
                SQ_IDLE: begin
                    if (q.pend) begin
                        d.pend     = 1'b0;
                        d.cur_data = q.pend_data;
                        d.cur_sel  = q.pend_sel;
                        d.cur_hold = q.pend_hold;
                        d.cnt      = '0;
                        if (q.cs_act && (q.cur_sel == q.pend_sel)) begin
                            d.st    = SQ_SHIFT;
                            d.start = 1'b1;
                        end else begin
                            d.cs_act = 1'b0;
                            d.st     = SQ_CS_GAP;
                        end
                    end
                end
                SQ_CS_GAP: begin
                    if (q.cnt == cs_last) begin
                        d.cnt    = '0;
                        d.cs_act = 1'b1;
                        d.st     = SQ_SHIFT;
                        d.start  = 1'b1;
                    end else begin
                        d.cnt = q.cnt + DLY_W'(1);
                    end
                end
                SQ_SHIFT: begin
                    if (shift_done_i) begin
                        if (!q.cur_hold) d.cs_act = 1'b0;
                        d.cnt = '0;
                        d.st  = SQ_XFER_GAP;
                    end
                end
                SQ_XFER_GAP: begin
                    if (q.cnt == xfer_last) begin
                        d.cnt = '0;
                        d.st  = SQ_IDLE;
                    end else begin
                        d.cnt = q.cnt + DLY_W'(1);
                    end
                end
                default: d.st = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SQ_IDLE;
        end else begin
            q <= d;
        end
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n_o[i] = !(q.cs_act && (q.cur_sel == SEL_W'(i)));
    end

    assign tx_empty_o = !q.pend;
    assign start_o    = q.start;
    assign abort_o    = !en_i;
    assign data_o     = q.cur_data;

    // R4
    cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    // R2
    pend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tx_empty_o) |=> $stable(q.pend_data));

    // R6
    held_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && q.st == SQ_SHIFT && shift_done_i && q.cur_hold) |=> $stable(cs_n_o));

    // R8
    off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cs_n_o == {NUM_CS{1'b1}}));

endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master #(
    parameter int DATA_W      = 8,
    parameter int NUM_CS      = 4,
    parameter int DIV_W       = 8,
    parameter int DLY_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_set_i,
    input  logic              stat_rd_i,
    input  logic              modf_off_i,
    input  logic [DIV_W-1:0]  clk_div_i,
    input  logic [DLY_W-1:0]  dly_xfer_i,
    input  logic [DLY_W-1:0]  dly_cs_i,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic [SEL_W-1:0]  tx_sel_i,
    input  logic              tx_hold_i,
    output logic              tx_empty_o,
    output logic              enabled_o,
    output logic              modf_o,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              nss_i,
    output logic [NUM_CS-1:0] cs_n_o
);

    logic              en;
    logic              start;
    logic              abort;
    logic              done;
    logic [DATA_W-1:0] cur_data;

    spim_modf_guard #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .nss_i        (nss_i),
        .detect_off_i (modf_off_i),
        .en_set_i     (en_set_i),
        .stat_rd_i    (stat_rd_i),
        .en_o         (en),
        .modf_o       (modf_o)
    );

    spim_seq #(
        .DATA_W (DATA_W),
        .NUM_CS (NUM_CS),
        .DLY_W  (DLY_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .wr_i         (tx_wr_i),
        .wr_data_i    (tx_data_i),
        .wr_sel_i     (tx_sel_i),
        .wr_hold_i    (tx_hold_i),
        .dly_xfer_i   (dly_xfer_i),
        .dly_cs_i     (dly_cs_i),
        .shift_done_i (done),
        .tx_empty_o   (tx_empty_o),
        .start_o      (start),
        .abort_o      (abort),
        .data_o       (cur_data),
        .cs_n_o       (cs_n_o)
    );

    spim_shift #(
        .DATA_W (DATA_W),
        .DIV_W  (DIV_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .abort_i (abort),
        .data_i  (cur_data),
        .div_i   (clk_div_i),
        .miso_i  (miso_i),
        .sck_o   (sck_o),
        .mosi_o  (mosi_o),
        .done_o  (done),
        .rx_o    (rx_data_o)
    );

    assign enabled_o  = en;
    assign rx_valid_o = done;

    // R8
    off_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled_o |=> !sck_o);

endmodule

// File: tb/spi_cs_master_bench.sv
`timescale 1ns/1ps
module spi_cs_master_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_set = 1'b0, stat_rd = 1'b0, modf_off = 1'b0;
    logic [7:0] clk_div = 8'd0, dly_xfer = 8'd0, dly_cs = 8'd0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'd0;
    logic [1:0] tx_sel = 2'd0;
    logic       tx_hold = 1'b0;
    logic       tx_empty, enabled, modf, rx_valid, sck, mosi, miso;
    logic       nss = 1'b1;
    logic [7:0] rx_data;
    logic [3:0] cs_n;

    always #5 clk = ~clk;

    spi_cs_master u_spi_cs_master (
        .clk(clk), .rst_n(rst_n), .en_set_i(en_set), .stat_rd_i(stat_rd),
        .modf_off_i(modf_off), .clk_div_i(clk_div), .dly_xfer_i(dly_xfer),
        .dly_cs_i(dly_cs), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
        .tx_sel_i(tx_sel), .tx_hold_i(tx_hold), .tx_empty_o(tx_empty),
        .enabled_o(enabled), .modf_o(modf), .rx_valid_o(rx_valid),
        .rx_data_o(rx_data), .sck_o(sck), .mosi_o(mosi), .miso_i(miso),
        .nss_i(nss), .cs_n_o(cs_n)
    );

    int checks = 0;
    int errors = 0;

    function automatic logic [7:0] reply(int k);
        return 8'((k * 91 + 60) & 255);
    endfunction

    function automatic int atleast1(logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    // ---------------- monitor and slave model (only writer of these) -------
    logic [7:0] sreg = 8'd0, sin = 8'd0;
    int         sbit = 0, s_idx = 0;
    logic       sck_prev = 1'b0;
    logic [7:0] cap_byte [256];
    int         cap_sel  [256];
    int         cap_n = 0;
    logic [7:0] rx_arr   [256];
    int         rx_n = 0;
    int         gap_arr  [256];
    int         gap_n = 0;
    int         hi_cnt = 0;
    int         skip_req = 0, skip_done = 0;
    int         sw = 0, last_sw = 0;

    assign miso = sreg[7];

    always @(negedge clk) begin
        if (cs_n == 4'hF) begin
            hi_cnt = hi_cnt + 1;
            sbit   = 0;
            sreg   = reply(s_idx);
        end else begin
            if (hi_cnt > 0) begin
                if (skip_req != skip_done) skip_done = skip_done + 1;
                else begin
                    gap_arr[gap_n] = hi_cnt;
                    gap_n = gap_n + 1;
                end
            end
            hi_cnt = 0;
            if (sck && !sck_prev) sin = {sin[6:0], mosi};
            if (!sck && sck_prev) begin
                sbit = sbit + 1;
                if (sbit == 8) begin
                    cap_byte[cap_n] = sin;
                    cap_sel[cap_n]  = -1;
                    for (int i = 0; i < 4; i++) if (!cs_n[i]) cap_sel[cap_n] = i;
                    cap_n = cap_n + 1;
                    s_idx = s_idx + 1;
                    sbit  = 0;
                    sreg  = reply(s_idx);
                end else begin
                    sreg = {sreg[6:0], 1'b0};
                end
            end
        end
        if (sck) sw = sw + 1;
        else if (sw > 0) begin
            last_sw = sw;
            sw = 0;
        end
        sck_prev = sck;
        if (rx_valid) begin
            rx_arr[rx_n] = rx_data;
            rx_n = rx_n + 1;
        end
    end

    // ---------------- bench bookkeeping --------------------------------
    logic [7:0] exp_byte [256];
    int         exp_sel  [256];
    int         exp_n = 0, byte_chk = 0;
    int         exp_gap  [256];
    string      exp_tag  [256];
    int         eg_n = 0, gap_chk = 0;
    bit         have_prev = 0;
    int         prev_sel = 0;
    bit         prev_hold = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic send_raw(input logic [7:0] d, input int s, input bit h);
        while (!tx_empty) @(negedge clk);
        tx_wr = 1'b1; tx_data = d; tx_sel = 2'(s); tx_hold = h;
        @(negedge clk);
        tx_wr = 1'b0;
        // R2: accepted write fills the holding stage
        chk(!tx_empty, "R2", "tx_empty after accepted write", int'(tx_empty), 0);
    endtask

    task automatic start_batch();
        skip_req++;
        have_prev = 0;
    endtask

    task automatic xfer(input logic [7:0] d, input int s, input bit h);
        if (have_prev) begin
            if (prev_hold && prev_sel == s) begin
                // R6: no release expected
            end else if (prev_hold) begin
                exp_gap[eg_n] = atleast1(dly_cs); exp_tag[eg_n] = "R7"; eg_n++;
            end else begin
                exp_gap[eg_n] = atleast1(dly_xfer) + 1 + atleast1(dly_cs);
                exp_tag[eg_n] = "R5"; eg_n++;
            end
        end
        have_prev = 1; prev_sel = s; prev_hold = h;
        exp_byte[exp_n] = d; exp_sel[exp_n] = s; exp_n++;
        send_raw(d, s, h);
    endtask

    task automatic end_batch();
        while (rx_n < exp_n) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(cap_n == exp_n, "R2", "transfer count", cap_n, exp_n);
        for (int k = byte_chk; k < exp_n; k++) begin
            chk(cap_byte[k] == exp_byte[k], "R3", "mosi byte", int'(cap_byte[k]), int'(exp_byte[k]));
            chk(rx_arr[k] == reply(k), "R3", "rx byte", int'(rx_arr[k]), int'(reply(k)));
            chk(cap_sel[k] == exp_sel[k], "R4", "active select", cap_sel[k], exp_sel[k]);
        end
        byte_chk = exp_n;
        chk(gap_n == eg_n, "R6", "number of select releases", gap_n, eg_n);
        for (int k = gap_chk; k < eg_n && k < gap_n; k++)
            chk(gap_arr[k] == exp_gap[k], exp_tag[k], "select gap", gap_arr[k], exp_gap[k]);
        gap_chk = eg_n;
        chk(last_sw == atleast1(clk_div), "R3", "sck high width", last_sw, atleast1(clk_div));
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic run_all();
        int cap0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == 4'hF, "R1", "cs_n", int'(cs_n), 15);
        chk(!sck, "R1", "sck", int'(sck), 0);
        chk(tx_empty, "R1", "tx_empty", int'(tx_empty), 1);
        chk(!modf, "R1", "modf", int'(modf), 0);
        chk(!enabled, "R1", "enabled", int'(enabled), 0);

        // R2: write while disabled is ignored
        tx_data = 8'h99; tx_sel = 2'd1;
        pulse(tx_wr);
        chk(tx_empty, "R2", "tx_empty after write while off", int'(tx_empty), 1);
        pulse(en_set);
        chk(enabled, "R1", "enabled after en_set", int'(enabled), 1);
        repeat (40) @(negedge clk);
        chk(cs_n == 4'hF && cap_n == 0, "R2", "no transfer from refused write", cap_n, 0);

        // Directed batch, minimum delays
        clk_div = 8'd0; dly_xfer = 8'd0; dly_cs = 8'd0;
        start_batch();
        xfer(8'hA5, 0, 0);
        xfer(8'h3C, 0, 0);
        chk(!tx_empty, "R2", "stage full before extra write", int'(tx_empty), 0);
        tx_data = 8'hEE; tx_sel = 2'd3; tx_hold = 1'b0;
        pulse(tx_wr);
        xfer(8'h81, 1, 1);
        xfer(8'h7E, 1, 1);
        xfer(8'h00, 1, 0);
        xfer(8'hFF, 3, 1);
        xfer(8'h5A, 2, 0);
        end_batch();

        // Directed batch, longer delays and divisor
        clk_div = 8'd3; dly_xfer = 8'd5; dly_cs = 8'd4;
        start_batch();
        xfer(8'h12, 2, 0);
        xfer(8'h34, 2, 1);
        xfer(8'h56, 0, 1);
        xfer(8'h78, 0, 0);
        end_batch();

        // Constrained random batches
        for (int b = 0; b < 4; b++) begin
            clk_div  = 8'($urandom_range(0, 3));
            dly_xfer = 8'($urandom_range(0, 6));
            dly_cs   = 8'($urandom_range(0, 6));
            start_batch();
            for (int t = 0; t < 12; t++)
                xfer(8'($urandom_range(0, 255)), int'($urandom_range(0, 3)),
                     (t == 11) ? 1'b0 : 1'($urandom_range(0, 1)));
            end_batch();
        end

        // R8 / R9: mode fault mid-transfer
        clk_div = 8'd8; dly_xfer = 8'd1; dly_cs = 8'd1;
        start_batch();
        cap0 = cap_n;
        send_raw(8'hC3, 2, 0);
        send_raw(8'h3C, 1, 0);
        repeat (10) @(negedge clk);
        chk(cs_n == 4'b1011, "R4", "select 2 active", int'(cs_n), 11);
        nss = 1'b0;
        repeat (5) @(negedge clk);
        chk(!enabled, "R8", "enabled after fault", int'(enabled), 0);
        chk(modf, "R8", "modf after fault", int'(modf), 1);
        chk(cs_n == 4'hF, "R8", "cs_n after fault", int'(cs_n), 15);
        chk(!sck, "R8", "sck after fault", int'(sck), 0);
        chk(tx_empty, "R8", "queued word dropped", int'(tx_empty), 1);
        tx_data = 8'h66; tx_sel = 2'd0;
        pulse(tx_wr);
        nss = 1'b1;
        repeat (30) @(negedge clk);
        chk(!enabled && cs_n == 4'hF, "R9", "stays off", int'(enabled), 0);
        chk(modf, "R9", "modf held until read", int'(modf), 1);
        pulse(stat_rd);
        chk(!modf, "R9", "modf cleared by read", int'(modf), 1'b0);
        pulse(en_set);
        chk(enabled, "R9", "enabled by en_set", int'(enabled), 1);
        repeat (200) @(negedge clk);
        chk(cap_n == cap0 && rx_n == exp_n, "R8", "aborted/dropped words not sent", cap_n, cap0);

        // R10: masked detection
        modf_off = 1'b1; clk_div = 8'd1; dly_xfer = 8'd2; dly_cs = 8'd3;
        start_batch();
        nss = 1'b0;
        xfer(8'hB7, 3, 0);
        xfer(8'h4D, 1, 0);
        end_batch();
        chk(!modf, "R10", "modf with detection masked", int'(modf), 0);
        chk(enabled, "R10", "enabled with detection masked", int'(enabled), 1);
        nss = 1'b1;
    endtask

    initial begin
        bit timed_out = 0;
        void'($urandom(32'h5EED_2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule